// File: doc/BRIEF.md
# Spread-Spectrum Two-Phase PWM Modulator

This block turns one channel of signed audio samples into a pair of pulse-width-modulated switching outputs for a filterless bridge-tied load. Both outputs start high at the beginning of every carrier period. With a zero sample they carry identical 50% waveforms, so the load sees no net voltage. A positive sample lengthens the high time of `out_p` and shortens that of `out_n` by the same number of clocks. A negative sample does the reverse.

The carrier period is counted in system clocks. In fixed mode every period has the nominal length, which is set by the ratio of the system clock to the carrier frequency. In spread mode each new period is drawn from a window around the nominal length. A 16-bit maximal-length LFSR supplies a random value, which is scaled into that window. The sample, the mode and the period are captured together only at a period boundary. The high times are computed from the period actually in force, so the modulation depth relative to the period stays the same whatever the dither picks. A channel enable starts and stops the carrier. While the channel is off, or while reset is active, both outputs stay low.

Top module: `sspwm_mod`

## Requirements
- R1: While `rst_n` is low, `out_p` and `out_n` are both low.
- R2: A low `chan_en` seen at a clock edge drives both outputs low from that edge onward. The first edge that sees `chan_en` high starts a fresh period at count zero, with both outputs high in that first clock when their high times are non-zero.
- R3: With a zero sample, `out_p` and `out_n` are high for the same first floor(P/2) clocks of each period of P clocks, so they never differ.
- R4: For a sample s (two's complement, `SAMPLE_W` bits) and period P, the high time of `out_p` is floor(P/2)+d and that of `out_n` is floor(P/2)-d, where d = floor(s·P / 2^SAMPLE_W). Both outputs go high at the first clock of the period.
- R5: With `spread_en` low at a boundary, the next period lasts exactly N = floor(CLK_HZ/CARRIER_HZ) clocks.
- R6: With `spread_en` high at a boundary, the next period length lies in [N-D, N+D], where D = floor(N·DITHER_PCT/100). The length is taken from a 16-bit maximal-length LFSR that steps once per period, so successive lengths vary.
- R7: The sample, the mode and the period length are captured only at a period boundary. A sample change in mid-period does not alter the high times of the period in progress.
- R8: High times saturate to the range 0..P and never wrap. The most negative sample keeps `out_p` low and `out_n` high for whole periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low holds both outputs low |
| spread_en | input | 1 | 1 = dithered period, 0 = fixed nominal period |
| sample_in | input | SAMPLE_W | Signed audio sample |
| out_p | output | 1 | Positive-phase switching output |
| out_n | output | 1 | Negative-phase switching output |

## Verification
The bench builds the block with an 8-bit sample, a 12 MHz system clock and a 300 kHz carrier, which gives a nominal period of 40 clocks, and a 30% dither, which gives a window of 28 to 52 clocks. Periods this short let the bench measure every period length and high time clock by clock. They also make full-scale saturation, odd period lengths under dither and a sample change in mid-period all reachable in a few hundred cycles. An 8-bit sample keeps the rounding of d easy to predict at both ends of the range.

// File: rtl/sspwm_pkg.sv
`timescale 1ns/1ps
package sspwm_pkg;

  localparam int LFSR_W = 16;
  // x^16 + x^14 + x^13 + x^11 + 1, Galois form, right-shifting
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  typedef logic [LFSR_W-1:0] lfsr_t;

  function automatic lfsr_t lfsr_advance(input lfsr_t cur);
    lfsr_t nxt;
    nxt = cur >> 1;
    if (cur[0]) nxt = nxt ^ LFSR_TAPS;
    return nxt;
  endfunction

  function automatic int dither_span(input int nominal, input int pct);
    return (nominal * pct) / 100;
  endfunction

endpackage

// File: rtl/sspwm_lfsr.sv
`timescale 1ns/1ps
module sspwm_lfsr
  import sspwm_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  output lfsr_t rnd
);

  lfsr_t state_q;
  lfsr_t state_n;

  always_comb begin
    state_n = state_q;
    if (step) state_n = lfsr_advance(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_n;
  end

  assign rnd = state_q;

  // R6: the generator never falls into the all-zero lock-up state
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R6: each step moves the sequence on
  a_r6_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state_q != $past(state_q));

endmodule

// File: rtl/sspwm_period.sv
`timescale 1ns/1ps
module sspwm_period
  import sspwm_pkg::*;
#(
  parameter int NOMINAL = 333,
  parameter int SPAN    = 99,
  parameter int PER_W   = 9
) (
  input  logic             spread_en,
  input  lfsr_t            rnd,
  output logic [PER_W-1:0] period
);

  generate
    if (SPAN == 0) begin : g_fixed
      assign period = PER_W'(NOMINAL);
    end else begin : g_spread
      localparam int RANGE  = 2 * SPAN + 1;
      localparam int RNG_W  = $clog2(RANGE + 1);
      localparam int PROD_W = LFSR_W + RNG_W;
      localparam logic [RNG_W-1:0] RANGE_V = RNG_W'(RANGE);

      logic [PROD_W-1:0] prod;
      logic [RNG_W-1:0]  offset;

      // multiply-high maps the 16-bit value uniformly onto 0..2*SPAN
      assign prod   = PROD_W'(rnd) * PROD_W'(RANGE_V);
      assign offset = prod[PROD_W-1 -: RNG_W];
      assign period = spread_en ? (PER_W'(NOMINAL - SPAN) + PER_W'(offset))
                                : PER_W'(NOMINAL);
    end
  endgenerate

endmodule

// File: rtl/sspwm_duty.sv
`timescale 1ns/1ps
module sspwm_duty #(
  parameter int SAMPLE_W = 16,
  parameter int PER_W    = 9
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [PER_W-1:0]    period,
  output logic        [PER_W-1:0]    hi_p,
  output logic        [PER_W-1:0]    hi_n
);

  localparam int PROD_W = SAMPLE_W + PER_W + 1;
  localparam int SUM_W  = PER_W + 2;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [SUM_W-1:0]  delta;
  logic signed [SUM_W-1:0]  half;
  logic signed [SUM_W-1:0]  per_s;
  logic signed [SUM_W-1:0]  raw_p;
  logic signed [SUM_W-1:0]  raw_n;

  function automatic logic [PER_W-1:0] clamp_hi(input logic signed [SUM_W-1:0] raw,
                                                 input logic signed [SUM_W-1:0] lim);
    if (raw < 0)        return '0;
    else if (raw > lim) return lim[PER_W-1:0];
    else                return raw[PER_W-1:0];
  endfunction

  always_comb begin
    prod   = $signed(sample) * $signed({1'b0, period});
    scaled = prod >>> SAMPLE_W;
    delta  = SUM_W'(scaled);
    half   = $signed({3'b000, period[PER_W-1:1]});
    per_s  = $signed({2'b00, period});
    raw_p  = half + delta;
    raw_n  = half - delta;
    hi_p   = clamp_hi(raw_p, per_s);
    hi_n   = clamp_hi(raw_n, per_s);
  end

endmodule

// File: rtl/sspwm_carrier.sv
`timescale 1ns/1ps
module sspwm_carrier #(
  parameter int PER_W   = 9,
  parameter int NOMINAL = 333
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic [PER_W-1:0] per_in,
  input  logic [PER_W-1:0] hp_in,
  input  logic [PER_W-1:0] hn_in,
  output logic             bnd,
  output logic             running,
  output logic [PER_W-1:0] cur_period,
  output logic             out_p,
  output logic             out_n
);

  logic             run_q, run_n;
  logic [PER_W-1:0] cnt_q, cnt_n;
  logic [PER_W-1:0] per_q, hp_q, hn_q;
  logic [PER_W-1:0] hp_eff, hn_eff;
  logic             op_q, op_n, on_q, on_n;

  assign bnd = chan_en && (!run_q || (cnt_q == per_q - 1'b1));

  always_comb begin
    run_n  = run_q;
    cnt_n  = cnt_q;
    hp_eff = hp_q;
    hn_eff = hn_q;
    if (!chan_en) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else if (bnd) begin
      run_n  = 1'b1;
      cnt_n  = '0;
      hp_eff = hp_in;
      hn_eff = hn_in;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
    op_n = chan_en && (cnt_n < hp_eff);
    on_n = chan_en && (cnt_n < hn_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      op_q  <= 1'b0;
      on_q  <= 1'b0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
      op_q  <= op_n;
      on_q  <= on_n;
    end
  end

  // period and high times: clock-enabled by the boundary strobe only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PER_W'(NOMINAL);
      hp_q  <= '0;
      hn_q  <= '0;
    end else if (bnd) begin
      per_q <= per_in;
      hp_q  <= hp_in;
      hn_q  <= hn_in;
    end
  end

  assign running    = run_q;
  assign cur_period = per_q;
  assign out_p      = op_q;
  assign out_n      = on_q;

  // R2: disabling silences both outputs at the next edge
  a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!out_p && !out_n));

  // R2: enabling from idle starts the count at zero
  a_r2_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !run_q) |=> (cnt_q == '0 && run_q));

  // R7: nothing latched changes inside a period
  a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && chan_en && !bnd) |=> ($stable(per_q) && $stable(hp_q) && $stable(hn_q)));

  // R8: high times never exceed the period
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (hp_q <= per_q && hn_q <= per_q));

endmodule

// File: rtl/sspwm_mod.sv
`timescale 1ns/1ps
module sspwm_mod
  import sspwm_pkg::*;
#(
  parameter int          SAMPLE_W   = 16,
  parameter int          CLK_HZ     = 100_000_000,
  parameter int          CARRIER_HZ = 300_000,
  parameter int          DITHER_PCT = 30,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       chan_en,
  input  logic                       spread_en,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic                       out_p,
  output logic                       out_n
);

  localparam int NOMINAL = CLK_HZ / CARRIER_HZ;
  localparam int SPAN    = dither_span(NOMINAL, DITHER_PCT);
  localparam int PER_MIN = NOMINAL - SPAN;
  localparam int PER_MAX = NOMINAL + SPAN;
  localparam int PER_W   = $clog2(PER_MAX + 1);

  lfsr_t            rnd;
  logic             bnd;
  logic             running;
  logic [PER_W-1:0] next_period;
  logic [PER_W-1:0] cur_period;
  logic [PER_W-1:0] hp_next;
  logic [PER_W-1:0] hn_next;

  sspwm_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (bnd),
    .rnd   (rnd)
  );

  sspwm_period #(.NOMINAL(NOMINAL), .SPAN(SPAN), .PER_W(PER_W)) u_period (
    .spread_en (spread_en),
    .rnd       (rnd),
    .period    (next_period)
  );

  sspwm_duty #(.SAMPLE_W(SAMPLE_W), .PER_W(PER_W)) u_duty (
    .sample (sample_in),
    .period (next_period),
    .hi_p   (hp_next),
    .hi_n   (hn_next)
  );

  sspwm_carrier #(.PER_W(PER_W), .NOMINAL(NOMINAL)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .per_in     (next_period),
    .hp_in      (hp_next),
    .hn_in      (hn_next),
    .bnd        (bnd),
    .running    (running),
    .cur_period (cur_period),
    .out_p      (out_p),
    .out_n      (out_n)
  );

  // R5: a boundary in fixed mode loads the nominal length
  a_r5_fixed_period: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && !spread_en) |=> cur_period == PER_W'(NOMINAL));

  // R6: every period in force lies inside the dither window
  a_r6_period_window: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cur_period >= PER_W'(PER_MIN) && cur_period <= PER_W'(PER_MAX)));

endmodule

// File: tb/sspwm_mod_bench.sv
`timescale 1ns/1ps
module sspwm_mod_bench;

  localparam int SW   = 8;
  localparam int NOM  = 40;
  localparam int SPAN = 12;

  logic                 clk;
  logic                 rst_n;
  logic                 chan_en;
  logic                 spread_en;
  logic signed [SW-1:0] sample;
  logic                 out_p;
  logic                 out_n;

  int n_checks;
  int n_errors;
  bit done;

  sspwm_mod #(
    .SAMPLE_W   (SW),
    .CLK_HZ     (12_000_000),
    .CARRIER_HZ (300_000),
    .DITHER_PCT (30),
    .LFSR_SEED  (16'hACE1)
  ) u_sspwm_mod (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .spread_en (spread_en),
    .sample_in (sample),
    .out_p     (out_p),
    .out_n     (out_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_hi(input int s, input int p, input bit pos);
    int half, d, r;
    half = p / 2;
    d    = (s * p) >>> SW;
    r    = pos ? half + d : half - d;
    if (r < 0) r = 0;
    if (r > p) r = p;
    return r;
  endfunction

  // Finds the next rising edge of out_p and measures that period.
  task automatic measure(output int per, output int hp, output int hn, output int mism);
    bit prev, found;
    prev = out_p; found = 0;
    per = 0; hp = 0; hn = 0; mism = 0;
    for (int i = 0; i < 200 && !found; i++) begin
      @(negedge clk);
      if (out_p && !prev) found = 1;
      else prev = out_p;
    end
    if (!found) begin
      check(0, "R4", "no period start seen", 0, 1);
      return;
    end
    per = 1; hp = int'(out_p); hn = int'(out_n); mism = int'(out_p != out_n);
    prev = out_p;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (out_p && !prev) break;
      per++;
      hp += int'(out_p);
      hn += int'(out_n);
      mism += int'(out_p != out_n);
      prev = out_p;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; chan_en = 1'b0; spread_en = 1'b0; sample = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!out_p && !out_n, "R1", "outputs in reset", int'({out_p, out_n}), 0);
    end
    chan_en = 1'b1;
    @(negedge clk);
    check(!out_p && !out_n, "R1", "outputs in reset with channel on", int'({out_p, out_n}), 0);
    rst_n = 1'b1; chan_en = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_p && !out_n, "R2", "outputs with channel off", int'({out_p, out_n}), 0);
  endtask

  task automatic t_zero_fixed;
    int per, hp, hn, mism;
    spread_en = 1'b0; sample = '0; chan_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      measure(per, hp, hn, mism);
      check(per == NOM, "R5", "fixed period", per, NOM);
      check(hp == NOM / 2, "R3", "out_p high time at zero", hp, NOM / 2);
      check(hn == NOM / 2, "R3", "out_n high time at zero", hn, NOM / 2);
      check(mism == 0, "R3", "cycles where outputs differ", mism, 0);
    end
  endtask

  task automatic t_duty_fixed;
    int vals[5] = '{64, -64, 100, -37, 127};
    int per, hp, hn, mism;
    spread_en = 1'b0;
    foreach (vals[i]) begin
      sample = SW'(vals[i]);
      measure(per, hp, hn, mism);
      check(per == NOM, "R5", "fixed period under signal", per, NOM);
      check(hp == exp_hi(vals[i], NOM, 1'b1), "R4", "out_p high time",
            hp, exp_hi(vals[i], NOM, 1'b1));
      check(hn == exp_hi(vals[i], NOM, 1'b0), "R4", "out_n high time",
            hn, exp_hi(vals[i], NOM, 1'b0));
    end
  endtask

  task automatic t_saturate;
    int cp, cn;
    spread_en = 1'b0;
    sample = SW'(-128);
    repeat (NOM + 5) @(negedge clk);
    cp = 0; cn = 0;
    for (int i = 0; i < 2 * NOM; i++) begin
      @(negedge clk);
      cp += int'(out_p);
      cn += int'(out_n);
    end
    check(cp == 0, "R8", "out_p highs at most negative sample", cp, 0);
    check(cn == 2 * NOM, "R8", "out_n highs at most negative sample", cn, 2 * NOM);
  endtask

  task automatic t_latch;
    bit prev, found;
    int cp, per, hp, hn, mism;
    spread_en = 1'b0; sample = '0;
    repeat (NOM + 2) @(negedge clk);
    prev = out_p; found = 0;
    for (int i = 0; i < 200 && !found; i++) begin
      @(negedge clk);
      if (out_p && !prev) found = 1;
      else prev = out_p;
    end
    cp = int'(out_p);
    for (int i = 1; i < NOM; i++) begin
      @(negedge clk);
      if (i == 5) sample = SW'(64);
      cp += int'(out_p);
    end
    check(cp == NOM / 2, "R7", "high time of period with mid-period change", cp, NOM / 2);
    measure(per, hp, hn, mism);
    check(hp == exp_hi(64, NOM, 1'b1), "R7", "high time after boundary",
          hp, exp_hi(64, NOM, 1'b1));
  endtask

  task automatic t_spread;
    int per, hp, hn, mism, pmin, pmax;
    spread_en = 1'b1; sample = SW'(64);
    measure(per, hp, hn, mism);
    pmin = 1000; pmax = 0;
    for (int k = 0; k < 16; k++) begin
      measure(per, hp, hn, mism);
      check(per >= NOM - SPAN && per <= NOM + SPAN, "R6", "dithered period in window",
            per, NOM);
      check(hp == exp_hi(64, per, 1'b1), "R4", "out_p high time at dithered period",
            hp, exp_hi(64, per, 1'b1));
      check(hn == exp_hi(64, per, 1'b0), "R4", "out_n high time at dithered period",
            hn, exp_hi(64, per, 1'b0));
      if (per < pmin) pmin = per;
      if (per > pmax) pmax = per;
    end
    check(pmax > pmin, "R6", "spread of period lengths", pmax - pmin, 1);
    spread_en = 1'b0;
    measure(per, hp, hn, mism);
    measure(per, hp, hn, mism);
    check(per == NOM, "R5", "period after leaving spread mode", per, NOM);
  endtask

  task automatic t_disable;
    int cp;
    spread_en = 1'b0; sample = '0;
    @(negedge clk);
    chan_en = 1'b0;
    @(negedge clk);
    check(!out_p && !out_n, "R2", "outputs one edge after disable", int'({out_p, out_n}), 0);
    cp = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cp += int'(out_p) + int'(out_n);
    end
    check(cp == 0, "R2", "highs while disabled", cp, 0);
    chan_en = 1'b1;
    @(negedge clk);
    check(out_p && out_n, "R2", "both high in first clock after enable", int'({out_p, out_n}), 3);
    cp = int'(out_p);
    for (int i = 1; i < NOM; i++) begin
      @(negedge clk);
      cp += int'(out_p);
    end
    check(cp == NOM / 2, "R2", "high time of first period after enable", cp, NOM / 2);
    @(negedge clk);
    check(out_p == 1'b1, "R2", "second period starts after nominal length", int'(out_p), 1);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 0;
    t_reset();
    t_zero_fixed();
    t_duty_fixed();
    t_saturate();
    t_latch();
    t_spread();
    t_disable();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule